// File: doc/BRIEF.md
# Radix Leaf-Entry Permission Check and Reference/Change Update

This block takes one leaf page-table entry that a table walker has already fetched, together with the memory address it came from, and answers one question for one access: is the access allowed, and with which read/write/execute rights? It also keeps the entry's usage history current. The block first checks whether the entry is guarded, meaning it is marked as non-idempotent I/O. It then works out the allowed rights from the entry's encoded authority. The problem-state bit, the scope of the check (process or partition) and a 3-bit authority-mask permission set can narrow those rights. It then compares the rights with the right the access type needs.

When the access is allowed, the block forms an updated entry in which the reference bit is always set. The change bit is set only for a store. For any access other than a store, the write right is withheld from the returned set. A later store therefore comes back through the block and sets the change bit. The block issues a write of the updated entry to its address only if the entry's value changed. It waits for that write to be accepted before it reports completion.

Requests enter on a valid/ready handshake: a request is taken in a cycle where both `req_valid` and `req_ready` are high, and `req_ready` is high only while the block is idle. The write-back leaves on a valid/ready handshake as well. Once `wr_valid` rises, the address and data stay fixed until the cycle in which `wr_ready` is high, so the memory side may stall for as long as it needs. Completion is a one-cycle `done` pulse. The `res_*` outputs stay valid from that pulse until the next request is taken.

Top module: `radix_pte_updater`

## Requirements
- R1: The attribute field is entry bits [5:4]; the value 2'b10 marks non-idempotent I/O. For an instruction fetch (access code 2'b10) to such an entry, the result is a fault with cause bit 0 (guarded/no-execute) alone, a permission set of 3'b000, and no write-back, whatever the authority bits hold.
- R2: Entry bit 3 is the privileged bit. In a process-scoped check (`req_partition`=0) of an entry with the privileged bit set, from problem state (`req_problem`=1), the permission set is empty.
- R3: In a process-scoped check of an entry with bit 3 clear, from privileged state (`req_problem`=0), the permission set is the entry authority bits [2:0] ANDed with `req_amr`. Bit order in both is {read, write, execute} = [2:0].
- R4: In every other case, including every partition-scoped check, the permission set is the entry authority bits [2:0] alone.
- R5: Access codes are 2'b00 load, 2'b01 store, 2'b10 fetch, 2'b11 treated as a load. Load needs read, store needs write, fetch needs execute. If the needed right is missing, the result is a fault. The cause is bit 0 for a fetch and bit 1 (protection) for a data access. `res_pte` returns the original entry, and no write-back takes place.
- R6: On success the updated entry has the reference bit (bit 8) set. The change bit (bit 7) is set for a store. For any other access the change bit keeps its original value, and all other bits are unchanged.
- R7: On success for a non-store access, the write bit is cleared in `res_perm`. For a store, `res_perm` is the full permission set.
- R8: The updated entry is written to `req_addr` only if it differs from the original entry. Otherwise no write is issued.
- R9: Without a write-back, `done` is high in the cycle after the request is taken. With a write-back, `wr_valid` rises in the cycle after the request is taken, holds its address and data until `wr_ready`, and `done` is high in the cycle after that handshake. `done` lasts one cycle.
- R10: `req_ready` is high only while the block is idle: it is high after reset and low from the cycle after a request is taken until the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_pte | input | 64 | Leaf entry to check |
| req_addr | input | ADDR_W | Memory address of the entry |
| req_access | input | 2 | Access code: load, store, fetch |
| req_problem | input | 1 | Access made from problem (user) state |
| req_partition | input | 1 | Partition-scoped check |
| req_amr | input | 3 | Authority-mask permissions {R,W,X} |
| wr_valid | output | 1 | Write-back request |
| wr_ready | input | 1 | Write-back accepted |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | 64 | Updated entry |
| done | output | 1 | One-cycle completion pulse |
| res_fault | output | 1 | Access denied |
| res_cause | output | 2 | Fault cause: bit 0 guarded/no-exec, bit 1 protection |
| res_perm | output | 3 | Granted permissions {R,W,X} |
| res_pte | output | 64 | Updated entry on success, original on fault |

## Verification
The bench builds the block with its default 56-bit entry address and also drives the top address bits with random values. This shows that `wr_addr` carries the full captured address and not a truncated one. Random entries draw every attribute, privilege and authority combination against every access code, scope and mask. Entries whose reference and change bits are already set show the no-write path beside the write path. Random `wr_ready` stalls of zero to four cycles bring the hold-under-back-pressure rule and the done timing within reach of the checks.

// File: rtl/radix_pte_pkg.sv
package radix_pte_pkg;
  localparam int PTE_W       = 64;
  localparam int PERM_W      = 3;
  localparam int EXEC_BIT    = 0;
  localparam int WRITE_BIT   = 1;
  localparam int READ_BIT    = 2;
  localparam int PRIV_BIT    = 3;
  localparam int ATTR_LO     = 4;
  localparam int CHG_BIT     = 7;
  localparam int REF_BIT     = 8;
  localparam logic [1:0] ATTR_NIIO = 2'b10;
  localparam int CAUSE_W     = 2;
  localparam int CAUSE_GUARD = 0;
  localparam int CAUSE_PROT  = 1;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WB   = 2'b01,
    ST_DONE = 2'b10
  } st_e;
endpackage

// File: rtl/radix_perm_eval.sv
module radix_perm_eval
  import radix_pte_pkg::*;
(
  input  logic [PERM_W-1:0]  eaa,
  input  logic               priv,
  input  logic [1:0]         attr,
  input  acc_e               acc,
  input  logic               problem,
  input  logic               partition,
  input  logic [PERM_W-1:0]  amr,
  output logic [PERM_W-1:0]  perm,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause
);
  logic [PERM_W-1:0] allowed;
  logic [PERM_W-1:0] need;
  logic              guarded;

  always_comb begin
    need = '0;
    unique case (acc)
      ACC_STORE: need[WRITE_BIT] = 1'b1;
      ACC_FETCH: need[EXEC_BIT]  = 1'b1;
      default:   need[READ_BIT]  = 1'b1;
    endcase
  end

  always_comb begin
    if (!partition && priv && problem)
      allowed = '0;
    else if (!partition && !priv && !problem)
      allowed = eaa & amr;
    else
      allowed = eaa;
  end

  assign guarded = (attr == ATTR_NIIO) && (acc == ACC_FETCH);

  always_comb begin
    perm  = allowed;
    fault = 1'b0;
    cause = '0;
    if (guarded) begin
      perm               = '0;
      fault              = 1'b1;
      cause[CAUSE_GUARD] = 1'b1;
    end else if ((need & ~allowed) != '0) begin
      fault = 1'b1;
      if (acc == ACC_FETCH) cause[CAUSE_GUARD] = 1'b1;
      else                  cause[CAUSE_PROT]  = 1'b1;
    end
  end
endmodule

// File: rtl/radix_rc_merge.sv
module radix_rc_merge
  import radix_pte_pkg::*;
(
  input  logic [PTE_W-1:0]  pte_in,
  input  acc_e              acc,
  input  logic [PERM_W-1:0] perm_in,
  output logic [PTE_W-1:0]  pte_out,
  output logic [PERM_W-1:0] perm_out,
  output logic              changed
);
  logic [PTE_W-1:0] set_mask;
  logic             is_store;

  assign is_store = (acc == ACC_STORE);

  always_comb begin
    set_mask          = '0;
    set_mask[REF_BIT] = 1'b1;
    set_mask[CHG_BIT] = is_store;
  end

  assign pte_out = pte_in | set_mask;
  assign changed = (pte_out != pte_in);

  always_comb begin
    perm_out = perm_in;
    if (!is_store) perm_out[WRITE_BIT] = 1'b0;
  end
endmodule

// File: rtl/radix_pte_updater.sv
module radix_pte_updater
  import radix_pte_pkg::*;
#(
  parameter int ADDR_W = 56
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [PTE_W-1:0]   req_pte,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_access,
  input  logic               req_problem,
  input  logic               req_partition,
  input  logic [PERM_W-1:0]  req_amr,
  output logic               wr_valid,
  input  logic               wr_ready,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [PTE_W-1:0]   wr_data,
  output logic               done,
  output logic               res_fault,
  output logic [CAUSE_W-1:0] res_cause,
  output logic [PERM_W-1:0]  res_perm,
  output logic [PTE_W-1:0]   res_pte
);
  st_e               state;
  acc_e              acc;
  acc_e              r_acc;
  logic [ADDR_W-1:0] r_addr;
  logic [PERM_W-1:0] ev_perm;
  logic              ev_fault;
  logic [CAUSE_W-1:0] ev_cause;
  logic [PTE_W-1:0]  mg_pte;
  logic [PERM_W-1:0] mg_perm;
  logic              mg_changed;
  logic              take;

  assign acc  = acc_e'(req_access);
  assign take = req_valid && req_ready;

  radix_perm_eval u_eval (
    .eaa       (req_pte[PERM_W-1:0]),
    .priv      (req_pte[PRIV_BIT]),
    .attr      (req_pte[ATTR_LO+1:ATTR_LO]),
    .acc       (acc),
    .problem   (req_problem),
    .partition (req_partition),
    .amr       (req_amr),
    .perm      (ev_perm),
    .fault     (ev_fault),
    .cause     (ev_cause)
  );

  radix_rc_merge u_merge (
    .pte_in   (req_pte),
    .acc      (acc),
    .perm_in  (ev_perm),
    .pte_out  (mg_pte),
    .perm_out (mg_perm),
    .changed  (mg_changed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_acc     <= ACC_LOAD;
      r_addr    <= '0;
      res_fault <= 1'b0;
      res_cause <= '0;
      res_perm  <= '0;
      res_pte   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (take) begin
          r_acc     <= acc;
          r_addr    <= req_addr;
          res_fault <= ev_fault;
          res_cause <= ev_cause;
          res_perm  <= ev_fault ? ev_perm : mg_perm;
          res_pte   <= ev_fault ? req_pte : mg_pte;
          state     <= (ev_fault || !mg_changed) ? ST_DONE : ST_WB;
        end
        ST_WB:   if (wr_ready) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign wr_valid  = (state == ST_WB);
  assign wr_addr   = r_addr;
  assign wr_data   = res_pte;
  assign done      = (state == ST_DONE);

  // R9: write-back held stable under back-pressure
  a_r9_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_addr));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: accepted request drops ready
  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R6: reference bit present in every successful result
  a_r6_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    done && !res_fault |-> res_pte[REF_BIT]);

  // R7: non-store success never grants write
  a_r7_no_write_grant: assert property (@(posedge clk) disable iff (!rst_n)
    done && !res_fault && r_acc != ACC_STORE |-> !res_perm[WRITE_BIT]);

  // R5: fault flag and cause vector agree, one cause at a time
  a_r5_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0(res_cause) && (res_fault == (res_cause != '0)));

  // R1: a guarded-fetch fault reports no permissions
  a_r1_guard_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    done && res_fault && r_acc == ACC_FETCH && res_pte[ATTR_LO+1:ATTR_LO] == ATTR_NIIO
      |-> res_perm == '0 && res_cause[CAUSE_GUARD]);
endmodule

// File: tb/test_radix_pte_updater.sv
module test_radix_pte_updater;
  localparam int AW = 56;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_pte = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]  req_access = '0;
  logic        req_problem = 1'b0;
  logic        req_partition = 1'b0;
  logic [2:0]  req_amr = '0;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [AW-1:0] wr_addr;
  logic [63:0] wr_data;
  logic        done;
  logic        res_fault;
  logic [1:0]  res_cause;
  logic [2:0]  res_perm;
  logic [63:0] res_pte;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  radix_pte_updater #(.ADDR_W(AW)) i_radix_pte_updater (
    .clk, .rst_n, .req_valid, .req_ready, .req_pte, .req_addr, .req_access,
    .req_problem, .req_partition, .req_amr, .wr_valid, .wr_ready, .wr_addr,
    .wr_data, .done, .res_fault, .res_cause, .res_perm, .res_pte
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected results from the requirements
  task automatic model(input logic [63:0] pte, input logic [1:0] acc, input logic prob,
                       input logic part, input logic [2:0] amr,
                       output logic flt, output logic [1:0] cause,
                       output logic [2:0] perm, output logic [63:0] npte, output logic wb);
    logic [2:0] set, need;
    set = (!part && pte[3] && prob) ? 3'b000 :             // R2
          (!part && !pte[3] && !prob) ? (pte[2:0] & amr) : // R3
          pte[2:0];                                         // R4
    need = (acc == 2'b01) ? 3'b010 : (acc == 2'b10) ? 3'b001 : 3'b100;
    flt = 0; cause = 0; perm = set; npte = pte; wb = 0;
    if (pte[5:4] == 2'b10 && acc == 2'b10) begin            // R1
      flt = 1; cause = 2'b01; perm = 3'b000;
    end else if ((need & ~set) != 0) begin                  // R5
      flt = 1; cause = (acc == 2'b10) ? 2'b01 : 2'b10;
    end else begin
      npte = pte | 64'h100 | ((acc == 2'b01) ? 64'h80 : 64'h0); // R6
      if (acc != 2'b01) perm[1] = 1'b0;                         // R7
      wb = (npte != pte);                                       // R8
    end
  endtask

  task automatic run_op(input logic [63:0] pte, input logic [AW-1:0] addr, input logic [1:0] acc,
                        input logic prob, input logic part, input logic [2:0] amr, input int delay);
    logic ef; logic [1:0] ec; logic [2:0] ep; logic [63:0] en; logic ew;
    int n; int waited; bit seen_wb; bit got;
    model(pte, acc, prob, part, amr, ef, ec, ep, en, ew);
    @(negedge clk);
    check("R10 ready when idle", {63'd0, req_ready}, 64'd1);
    req_pte = pte; req_addr = addr; req_access = acc; req_problem = prob;
    req_partition = part; req_amr = amr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 busy after take", {63'd0, req_ready}, 64'd0);
    n = 1; waited = 0; seen_wb = 0; got = 0;
    while (n < 40 && !got) begin
      if (done) begin
        got = 1;
        check("R9 done latency", 64'(n), ew ? 64'(2 + delay) : 64'd1);
        check("R1 R5 fault", {63'd0, res_fault}, {63'd0, ef});
        check("R1 R5 cause", {62'd0, res_cause}, {62'd0, ec});
        check("R2 R3 R4 R7 perm", {61'd0, res_perm}, {61'd0, ep});
        check("R6 entry", res_pte, en);
        check("R8 write issued", {63'd0, seen_wb}, {63'd0, ew});
      end else begin
        if (wr_valid) begin
          seen_wb = 1;
          check("R8 wr_addr", {8'd0, wr_addr}, {8'd0, addr});
          check("R8 wr_data", wr_data, en);
          wr_ready = (waited >= delay);
          waited++;
        end
        @(negedge clk);
        wr_ready = 1'b0;
        n++;
      end
    end
    if (!got) check("R9 done seen", 64'd0, 64'd1);
    @(negedge clk);
    check("R9 done one cycle", {63'd0, done}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10 reset ready", {63'd0, req_ready}, 64'd1);
    check("R9 reset done", {63'd0, done}, 64'd0);
    check("R8 reset wr_valid", {63'd0, wr_valid}, 64'd0);
    rst_n = 1'b1;
    // R1: guarded fetch despite full authority
    run_op(64'h0000_0000_0000_0027, 56'hAB_CDEF_0123_4567, 2'b10, 0, 0, 3'b111, 0);
    // R2: privileged entry from problem state, load
    run_op(64'h0000_0000_0000_000F, 56'h10, 2'b00, 1, 0, 3'b111, 0);
    // R3: mask removes write for a store
    run_op(64'h0000_0000_0000_0007, 56'h20, 2'b01, 0, 0, 3'b101, 0);
    // R4: partition-scoped ignores mask and privilege, store with stall
    run_op(64'h0000_0000_0000_000A, 56'h30, 2'b01, 1, 1, 3'b000, 3);
    // R6 R8: ref already set, load needs no write-back
    run_op(64'h0000_0000_0000_0104, 56'h40, 2'b00, 0, 1, 3'b000, 0);
    // R6 R8: ref and change set, store needs no write-back
    run_op(64'h0000_0000_0000_0186, 56'h50, 2'b01, 0, 1, 3'b000, 2);
    // R5: fetch without execute right
    run_op(64'h0000_0000_0000_0006, 56'h60, 2'b10, 0, 1, 3'b000, 0);
    // R5: reserved code acts as load
    run_op(64'h0000_0000_0000_0002, 56'h70, 2'b11, 0, 1, 3'b000, 0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] p;
      p = {$urandom, $urandom};
      if ($urandom % 3 == 0) p[8:7] = 2'b11;
      run_op(p, {$urandom, $urandom}, 2'($urandom), 1'($urandom), 1'($urandom),
             3'($urandom), int'($urandom % 5));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule